// File: doc/BRIEF.md
# Store Alignment and Lane Merge

This block sits between a 32-bit core's store path and a small data cache whose lines are four words wide. It takes one store request per strobe. A request carries an address, an access size (byte, halfword or word), the store data, a byte-order select and an enable for alignment checking. The block first decides whether the access is legal. A misaligned word or halfword raises an alignment fault when checking is on, and a size code outside the three defined ones raises a type error. If the access is legal and the cache reports both a hit and that caching is on, the store data is merged into the right word and byte lanes of the line supplied with the request.

All results are registered. One cycle after the strobe the block presents the resulting line, a strobe saying whether that line was modified, the fault and error flags, and a copy of the write request for the memory path. The memory copy is issued for every legal store, whether or not the cache hit. The caller looks up the tag and translates the address before this block sees the request. The caller also returns the line to the cache and carries out the memory write.

Top module: `store_lane_merge`

## Requirements
- R1: A word store (size code 2'b10) whose address bits [1:0] are not 00 raises `align_fault_o` when `align_chk_i` is 1. It raises no fault when `align_chk_i` is 0.
- R2: A halfword store (size code 2'b01) with address bit 0 set raises `align_fault_o` when `align_chk_i` is 1. It raises no fault when `align_chk_i` is 0.
- R3: A byte store (size code 2'b00) never raises `align_fault_o`, at any address and with any check setting.
- R4: The word of the line that is modified is number addr[3:2], which occupies bits [32*n+31:32*n] of `line_i`/`line_o`. The other three words come out unchanged.
- R5: A halfword store replaces only the 16-bit field starting at bit 8*((big*2) XOR (addr & 2)) of the selected word, using data bits [15:0]. All other bits are kept.
- R6: A byte store replaces only the 8-bit field starting at bit 8*((big*3) XOR (addr & 3)) of the selected word, using data bits [7:0]. All other bits are kept.
- R7: A word store replaces all 32 bits of the selected word.
- R8: The line is modified, and `line_wr_o` is 1, only when `cache_en_i` and `hit_i` are both 1 and the request has neither a fault nor a type error. Otherwise `line_o` equals `line_i` as sampled with the request.
- R9: Size code 2'b11 raises `type_err_o` and suppresses both `line_wr_o` and `mem_wr_o`. It never raises `align_fault_o`.
- R10: `rsp_valid_o`, the flags, `line_o` and the memory request are registered and appear in the cycle after `req_i`. With no request the strobes `rsp_valid_o`, `line_wr_o` and `mem_wr_o` and the flags are 0.
- R11: For every legal store, `mem_wr_o` is 1 and `mem_addr_o`, `mem_data_o` and `mem_size_o` copy the request, whatever the state of `hit_i` or `cache_en_i`.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Store request strobe |
| vaddr_i | input | 32 | Store address |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| wdata_i | input | 32 | Store data, right-justified for sub-word sizes |
| big_end_i | input | 1 | 1 selects big-endian lane numbering |
| align_chk_i | input | 1 | Enables alignment faults |
| cache_en_i | input | 1 | Caching enabled |
| hit_i | input | 1 | Lookup hit for this line |
| line_i | input | 128 | Current line contents, word 0 in bits [31:0] |
| rsp_valid_o | output | 1 | Result valid, one cycle after the request |
| line_o | output | 128 | Resulting line |
| line_wr_o | output | 1 | Line was modified and must be written back |
| align_fault_o | output | 1 | Alignment fault |
| type_err_o | output | 1 | Reserved size code used |
| mem_wr_o | output | 1 | Memory write request |
| mem_addr_o | output | 32 | Memory write address |
| mem_data_o | output | 32 | Memory write data |
| mem_size_o | output | 2 | Memory write size code |

## Verification
There is no state carried between requests, so an internal error shows up at the ports in the single response cycle that follows the faulty request. A wrong lane decode corrupts specific bits of `line_o`. A wrong word index disturbs a neighbouring word. A fault or gating error shows up as a stray or missing `line_wr_o` or `mem_wr_o`. For each response the bench compares the whole 128-bit line against a model built from the offset formulas, for both byte orders. That comparison catches a single misplaced lane in the same cycle it appears.

// File: rtl/slm_pkg.sv
package slm_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } slm_size_e;
endpackage

// File: rtl/slm_align_chk.sv
module slm_align_chk
   import slm_pkg::*;
(
   input  logic [1:0] addr_lo_i,
   input  logic [1:0] size_i,
   input  logic       chk_en_i,
   output logic       fault_o,
   output logic       type_err_o
);
   always_comb begin
      fault_o    = 1'b0;
      type_err_o = 1'b0;
      case (size_i)
         SZ_BYTE: fault_o = 1'b0;
         SZ_HALF: fault_o = chk_en_i & addr_lo_i[0];
         SZ_WORD: fault_o = chk_en_i & (|addr_lo_i);
         default: type_err_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/slm_lane_merge.sv
module slm_lane_merge
   import slm_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] old_word_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [1:0]        addr_lo_i,
   input  logic [1:0]        size_i,
   input  logic              big_end_i,
   output logic [DATA_W-1:0] new_word_o
);
   localparam int LANES = DATA_W / 8;

   if (DATA_W != 32) begin : g_bad_width
      $error("slm_lane_merge: DATA_W must be 32");
   end

   logic [1:0] byte_lane;
   logic       half_hi;

   assign byte_lane = addr_lo_i ^ {2{big_end_i}};
   assign half_hi   = addr_lo_i[1] ^ big_end_i;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic       en;
      logic [7:0] src;
      always_comb begin
         en  = 1'b0;
         src = wdata_i[8*k +: 8];
         case (size_i)
            SZ_BYTE: begin
               en  = (byte_lane == 2'(k));
               src = wdata_i[7:0];
            end
            SZ_HALF: begin
               en  = (half_hi == 1'((k >> 1) & 1));
               src = wdata_i[8*(k % 2) +: 8];
            end
            SZ_WORD: en = 1'b1;
            default: en = 1'b0;
         endcase
      end
      assign new_word_o[8*k +: 8] = en ? src : old_word_i[8*k +: 8];
   end
endmodule

// File: rtl/slm_line_update.sv
module slm_line_update #(
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   localparam int IDX_W     = $clog2(LINE_WORDS),
   localparam int LINE_W    = DATA_W * LINE_WORDS
) (
   input  logic [LINE_W-1:0] line_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] new_word_i,
   input  logic              wr_en_i,
   output logic [DATA_W-1:0] old_word_o,
   output logic [LINE_W-1:0] line_o
);
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_depth
      $error("slm_line_update: LINE_WORDS must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] words [LINE_WORDS];

   for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
      assign words[w] = line_i[w*DATA_W +: DATA_W];
      assign line_o[w*DATA_W +: DATA_W] =
         (wr_en_i && idx_i == IDX_W'(w)) ? new_word_i : words[w];
   end

   assign old_word_o = words[idx_i];
endmodule

// File: rtl/store_lane_merge.sv
module store_lane_merge
   import slm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   localparam int IDX_W     = $clog2(LINE_WORDS),
   localparam int LINE_W    = DATA_W * LINE_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] vaddr_i,
   input  logic [1:0]        size_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              big_end_i,
   input  logic              align_chk_i,
   input  logic              cache_en_i,
   input  logic              hit_i,
   input  logic [LINE_W-1:0] line_i,
   output logic              rsp_valid_o,
   output logic [LINE_W-1:0] line_o,
   output logic              line_wr_o,
   output logic              align_fault_o,
   output logic              type_err_o,
   output logic              mem_wr_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_data_o,
   output logic [1:0]        mem_size_o
);
   if (ADDR_W < 2 + IDX_W) begin : g_bad_addr
      $error("store_lane_merge: ADDR_W too narrow for line index");
   end

   logic              fault_d, terr_d, legal_d, upd_d;
   logic [IDX_W-1:0]  widx;
   logic [DATA_W-1:0] old_word, new_word;
   logic [LINE_W-1:0] line_d;

   assign widx = vaddr_i[2 +: IDX_W];

   slm_align_chk u_chk (
      .addr_lo_i (vaddr_i[1:0]),
      .size_i    (size_i),
      .chk_en_i  (align_chk_i),
      .fault_o   (fault_d),
      .type_err_o(terr_d)
   );

   assign legal_d = ~fault_d & ~terr_d;
   assign upd_d   = legal_d & cache_en_i & hit_i;

   slm_lane_merge #(.DATA_W(DATA_W)) u_merge (
      .old_word_i(old_word),
      .wdata_i   (wdata_i),
      .addr_lo_i (vaddr_i[1:0]),
      .size_i    (size_i),
      .big_end_i (big_end_i),
      .new_word_o(new_word)
   );

   slm_line_update #(.DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)) u_line (
      .line_i    (line_i),
      .idx_i     (widx),
      .new_word_i(new_word),
      .wr_en_i   (upd_d),
      .old_word_o(old_word),
      .line_o    (line_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o   <= 1'b0;
         line_wr_o     <= 1'b0;
         align_fault_o <= 1'b0;
         type_err_o    <= 1'b0;
         mem_wr_o      <= 1'b0;
         line_o        <= '0;
         mem_addr_o    <= '0;
         mem_data_o    <= '0;
         mem_size_o    <= '0;
      end else begin
         rsp_valid_o   <= req_i;
         line_wr_o     <= req_i & upd_d;
         align_fault_o <= req_i & fault_d;
         type_err_o    <= req_i & terr_d;
         mem_wr_o      <= req_i & legal_d;
         if (req_i) begin
            line_o     <= line_d;
            mem_addr_o <= vaddr_i;
            mem_data_o <= wdata_i;
            mem_size_o <= size_i;
         end
      end
   end
endmodule

// File: rtl/slm_checker.sv
module slm_checker
   import slm_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic [ADDR_W-1:0] vaddr_i,
   input logic [1:0]        size_i,
   input logic              align_chk_i,
   input logic              cache_en_i,
   input logic              hit_i,
   input logic              rsp_valid_o,
   input logic              line_wr_o,
   input logic              align_fault_o,
   input logic              type_err_o,
   input logic              mem_wr_o
);
   p_word_misalign_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_i && size_i == SZ_WORD && align_chk_i && vaddr_i[1:0] != 2'b00 |=> align_fault_o);

   p_half_odd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_i && size_i == SZ_HALF && align_chk_i && vaddr_i[0] |=> align_fault_o);

   p_byte_nofault_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_i && size_i == SZ_BYTE |=> !align_fault_o);

   p_no_hit_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_i && !(cache_en_i && hit_i) |=> !line_wr_o);

   p_fault_blocks_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (align_fault_o || type_err_o) |-> !line_wr_o && !mem_wr_o);

   p_err_not_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
      type_err_o |-> !align_fault_o);

   p_resp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> rsp_valid_o);

   p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid_o |-> !line_wr_o && !mem_wr_o && !align_fault_o && !type_err_o);

   p_legal_goes_to_mem_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o && !align_fault_o && !type_err_o |-> mem_wr_o);
endmodule

bind store_lane_merge slm_checker #(.ADDR_W(ADDR_W)) u_slm_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_i        (req_i),
   .vaddr_i      (vaddr_i),
   .size_i       (size_i),
   .align_chk_i  (align_chk_i),
   .cache_en_i   (cache_en_i),
   .hit_i        (hit_i),
   .rsp_valid_o  (rsp_valid_o),
   .line_wr_o    (line_wr_o),
   .align_fault_o(align_fault_o),
   .type_err_o   (type_err_o),
   .mem_wr_o     (mem_wr_o)
);

// File: tb/store_lane_merge_tb_top.sv
module store_lane_merge_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_i = 1'b0;
   logic [31:0]  vaddr_i = '0;
   logic [1:0]   size_i = '0;
   logic [31:0]  wdata_i = '0;
   logic         big_end_i = 1'b0;
   logic         align_chk_i = 1'b0;
   logic         cache_en_i = 1'b0;
   logic         hit_i = 1'b0;
   logic [127:0] line_i = '0;
   logic         rsp_valid_o, line_wr_o, align_fault_o, type_err_o, mem_wr_o;
   logic [127:0] line_o;
   logic [31:0]  mem_addr_o, mem_data_o;
   logic [1:0]   mem_size_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   store_lane_merge dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .vaddr_i(vaddr_i),
      .size_i(size_i), .wdata_i(wdata_i), .big_end_i(big_end_i),
      .align_chk_i(align_chk_i), .cache_en_i(cache_en_i), .hit_i(hit_i),
      .line_i(line_i), .rsp_valid_o(rsp_valid_o), .line_o(line_o),
      .line_wr_o(line_wr_o), .align_fault_o(align_fault_o),
      .type_err_o(type_err_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
      .mem_data_o(mem_data_o), .mem_size_o(mem_size_o)
   );

   task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [127:0] model_line(logic [31:0] a, logic [1:0] sz,
         logic [31:0] d, logic big, logic [127:0] ln, logic upd);
      logic [127:0] r = ln;
      int base = 32 * int'(a[3:2]);
      int off;
      if (!upd) return r;
      case (sz)
         2'b00: begin
            off = 8 * ((int'(big) * 3) ^ int'(a[1:0]));
            r[base + off +: 8] = d[7:0];
         end
         2'b01: begin
            off = 8 * ((int'(big) * 2) ^ (int'(a[1:0]) & 2));
            r[base + off +: 16] = d[15:0];
         end
         2'b10: r[base +: 32] = d;
         default: ;
      endcase
      return r;
   endfunction

   task automatic run_req(logic [31:0] a, logic [1:0] sz, logic [31:0] d,
         logic big, logic chk, logic ce, logic hit, logic [127:0] ln, string tag);
      logic flt, err, upd;
      logic [127:0] exp_ln;
      @(negedge clk);
      req_i = 1'b1; vaddr_i = a; size_i = sz; wdata_i = d; big_end_i = big;
      align_chk_i = chk; cache_en_i = ce; hit_i = hit; line_i = ln;
      @(negedge clk);
      req_i = 1'b0;
      err = (sz == 2'b11);
      flt = chk && ((sz == 2'b10 && a[1:0] != 0) || (sz == 2'b01 && a[0]));
      upd = ce && hit && !flt && !err;
      exp_ln = model_line(a, sz, d, big, ln, upd);
      check({"R10 rsp_valid ", tag}, 128'(rsp_valid_o), 128'(1));
      check({"fault ", tag}, 128'(align_fault_o), 128'(flt));
      check({"R9 type_err ", tag}, 128'(type_err_o), 128'(err));
      check({"R8 line_wr ", tag}, 128'(line_wr_o), 128'(upd));
      check({"line ", tag}, line_o, exp_ln);
      check({"R11 mem_wr ", tag}, 128'(mem_wr_o), 128'(!flt && !err));
      if (!flt && !err)
         check({"R11 mem_req ", tag}, {62'd0, mem_size_o, mem_addr_o, mem_data_o},
               {62'd0, sz, a, d});
   endtask

   initial begin
      logic [127:0] ln0 = 128'h33333333_22222222_11111111_00000000;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R12 reset outs", {rsp_valid_o, line_wr_o, align_fault_o, type_err_o, mem_wr_o,
            mem_size_o, mem_addr_o, mem_data_o, line_o[50:0]}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 idle quiet", {rsp_valid_o, line_wr_o, mem_wr_o}, '0);
      // directed corners
      run_req(32'h1002, 2'b10, 32'hDEADBEEF, 0, 1, 1, 1, ln0, "R1 word misaligned chk on");
      run_req(32'h1003, 2'b10, 32'hDEADBEEF, 0, 0, 1, 1, ln0, "R1 word misaligned chk off");
      run_req(32'h1005, 2'b01, 32'h0000ABCD, 1, 1, 1, 1, ln0, "R2 half odd chk on");
      run_req(32'h1005, 2'b01, 32'h0000ABCD, 1, 0, 1, 1, ln0, "R2 half odd chk off");
      run_req(32'h100F, 2'b00, 32'h000000A5, 0, 1, 1, 1, ln0, "R3 R6 byte odd le");
      run_req(32'h100F, 2'b00, 32'h000000A5, 1, 1, 1, 1, ln0, "R3 R6 byte odd be");
      run_req(32'h1006, 2'b01, 32'h00001234, 0, 1, 1, 1, ln0, "R5 half le hi");
      run_req(32'h1006, 2'b01, 32'h00001234, 1, 1, 1, 1, ln0, "R5 half be");
      run_req(32'h1008, 2'b10, 32'hCAFEF00D, 0, 1, 1, 1, ln0, "R4 R7 word idx2");
      run_req(32'h100C, 2'b10, 32'hCAFEF00D, 1, 1, 1, 0, ln0, "R8 miss no write");
      run_req(32'h1004, 2'b10, 32'hCAFEF00D, 0, 1, 0, 1, ln0, "R8 cache off");
      run_req(32'h1000, 2'b11, 32'h55555555, 0, 1, 1, 1, ln0, "R9 reserved size");
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a = $urandom;
         logic [1:0]  sz = 2'($urandom);
         logic [127:0] ln = {$urandom, $urandom, $urandom, $urandom};
         string t;
         case (sz)
            2'b00: t = "R6 rand byte";
            2'b01: t = "R5 rand half";
            2'b10: t = "R7 R4 rand word";
            default: t = "R9 rand rsvd";
         endcase
         run_req(a, sz, $urandom, 1'($urandom), 1'($urandom), ($urandom % 4) != 0,
                 ($urandom % 4) != 0, ln, t);
      end
      @(negedge clk);
      check("R10 quiet after", {rsp_valid_o, line_wr_o, mem_wr_o}, '0);
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired act=running exp=done");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule